// File: doc/BRIEF.md
# MI Coherence Home Directory

This block is the home node for a group of private caches that keep lines in only two states, Modified or Invalid. For every tracked block it holds one owner record: a valid flag and the ID of the node that has the line in M. Caches send it exclusive-access requests (GETX) and writebacks on one valid/ready channel. A DMA engine sends reads and writes on a second channel. The directory answers on a single cache-bound response channel, drives a simple memory request/response port and returns DMA results on a DMA response port. It has no sharer set, no timers and no retry logic.

The controller serves one transaction at a time through a four-state machine. `ST_IDLE` accepts a request; the transition *accept* takes it to `ST_EXEC`. `ST_EXEC` looks up the owner and either finishes the transaction (transition *done* back to `ST_IDLE`), starts a memory fetch (transition *fetch* to `ST_MEMW`) or sends an invalidation for a DMA access (transition *invalidate* to `ST_INVW`). `ST_MEMW` waits for the memory response (transition *fill* to `ST_IDLE`). `ST_INVW` waits for the old owner to return its data (transition *recall* to `ST_IDLE`). Both input channels are held off while the controller is not idle.

Top module: `mi_home_dir`

## Requirements
- R1: After reset every block has no owner, both input ready signals are high and `rsp_valid`, `mem_req_valid` and `dma_rsp_valid` are low.
- R2: A GETX (`req_wb`=0) to a block with no owner issues a memory read (`mem_req_write`=0) for that block in the cycle after acceptance. In the cycle `mem_rsp_valid` is high, a response of kind DATA (`rsp_kind`=0) carrying the memory data goes to the requester, which becomes the owner.
- R3: A GETX to an owned block sends, in the cycle after acceptance, a response of kind FWD (`rsp_kind`=1) to the current owner with `rsp_src` set to the requester, with no memory access. The requester becomes the owner at once, even when it was already the owner.
- R4: A writeback (`req_wb`=1) from the current owner writes its data to memory and sends kind ACK (`rsp_kind`=2) to that node in the same cycle, one cycle after acceptance. The block is left with no owner.
- R5: A writeback from a node that is not the owner, or to a block with no owner, gets kind NACK (`rsp_kind`=3), writes no memory and leaves the owner unchanged.
- R6: A DMA access to an owned block sends kind INV (`rsp_kind`=4) to the owner one cycle after acceptance. In the cycle `own_valid` is high, memory is written (the DMA data for a write, the owner's data for a read), `dma_rsp_valid` pulses with the owner's data for a read or zero for a write, and the block is left with no owner.
- R7: A DMA access to a block with no owner goes to memory. A write issues a memory write and a `dma_rsp_valid` pulse with zero data, both one cycle after acceptance. A read issues a memory read and returns the memory data on the DMA port in the cycle `mem_rsp_valid` is high.
- R8: While a memory fetch or an owner recall is outstanding, `req_ready` and `dma_ready` are both low.
- R9: When both channels are valid in the idle state, the cache channel is accepted and `dma_ready` is low. The DMA request is taken once the controller is idle again.
- R10: No timeout exists: an outstanding fetch waits indefinitely, with no output activity, until `mem_rsp_valid` arrives.
- R11: Addresses 0 and BLOCKS-1 are tracked independently of the other blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cache request present |
| req_ready | output | 1 | Cache request accepted this cycle when valid |
| req_wb | input | 1 | 0 = GETX, 1 = writeback |
| req_addr | input | AW | Block address |
| req_node | input | NW | Requesting node ID |
| req_data | input | DW | Writeback data |
| dma_valid | input | 1 | DMA request present |
| dma_ready | output | 1 | DMA request accepted this cycle when valid |
| dma_write | input | 1 | 1 = DMA write, 0 = DMA read |
| dma_addr | input | AW | DMA block address |
| dma_data | input | DW | DMA write data |
| rsp_valid | output | 1 | Cache-bound message valid (one-cycle pulse) |
| rsp_kind | output | 3 | 0 DATA, 1 FWD, 2 ACK, 3 NACK, 4 INV |
| rsp_node | output | NW | Destination node |
| rsp_src | output | NW | Requester carried by FWD, else 0 |
| rsp_addr | output | AW | Block address of the message |
| rsp_data | output | DW | Block data for DATA, else 0 |
| own_valid | input | 1 | Invalidated owner returns its data |
| own_data | input | DW | Data returned by the owner |
| mem_req_valid | output | 1 | Memory request (one-cycle pulse) |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Memory block address |
| mem_req_data | output | DW | Memory write data, 0 for reads |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_data | input | DW | Memory read data |
| dma_rsp_valid | output | 1 | DMA completion (one-cycle pulse) |
| dma_rsp_data | output | DW | DMA read data, 0 for writes |

## Verification
Every decision made from the owner table (FWD, ACK, NACK, INV, a memory read or write, or a DMA write completion) is due in the single `ST_EXEC` cycle that follows the accepting clock edge. Fill and recall results are due in the same cycle that `mem_rsp_valid` or `own_valid` is high. The driver predicts each event from its own owner model and queues it before raising the stimulus. The monitor samples the output valids once per cycle, late in the low clock phase, so every queued event must appear in exactly the cycle named above, and any extra pulse is reported as unexpected.

// File: rtl/mi_dir_pkg.sv
package mi_dir_pkg;

    typedef enum logic [2:0] {
        RK_DATA = 3'd0,
        RK_FWD  = 3'd1,
        RK_ACK  = 3'd2,
        RK_NACK = 3'd3,
        RK_INV  = 3'd4
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_MEMW = 2'd2,
        ST_INVW = 2'd3
    } dir_state_e;

endpackage

// File: rtl/mi_owner_table.sv
module mi_owner_table #(
    parameter  int BLOCKS = 16,
    parameter  int NODES  = 4,
    localparam int AW     = $clog2(BLOCKS),
    localparam int NW     = $clog2(NODES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_vld,
    output logic [NW-1:0] rd_node,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_vld,
    input  logic [NW-1:0] wr_node
);

    logic [BLOCKS-1:0] vld_q;
    logic [NW-1:0]     node_q [BLOCKS];

    for (genvar i = 0; i < BLOCKS; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[i]  <= 1'b0;
                node_q[i] <= '0;
            end else if (wr_en && wr_addr == AW'(i)) begin
                vld_q[i]  <= wr_vld;
                node_q[i] <= wr_node;
            end
        end
    end

    assign rd_vld  = vld_q[rd_addr];
    assign rd_node = node_q[rd_addr];

endmodule

// File: rtl/mi_dir_arb.sv
module mi_dir_arb (
    input  logic idle,
    input  logic req_valid,
    input  logic dma_valid,
    output logic req_ready,
    output logic dma_ready,
    output logic take_req,
    output logic take_dma
);

    assign req_ready = idle;
    assign dma_ready = idle & ~req_valid;
    assign take_req  = req_valid & req_ready;
    assign take_dma  = dma_valid & dma_ready;

endmodule

// File: rtl/mi_home_dir.sv
module mi_home_dir
    import mi_dir_pkg::*;
#(
    parameter  int BLOCKS = 16,
    parameter  int NODES  = 4,
    parameter  int DW     = 32,
    localparam int AW     = $clog2(BLOCKS),
    localparam int NW     = $clog2(NODES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_wb,
    input  logic [AW-1:0] req_addr,
    input  logic [NW-1:0] req_node,
    input  logic [DW-1:0] req_data,
    input  logic          dma_valid,
    output logic          dma_ready,
    input  logic          dma_write,
    input  logic [AW-1:0] dma_addr,
    input  logic [DW-1:0] dma_data,
    output logic          rsp_valid,
    output logic [2:0]    rsp_kind,
    output logic [NW-1:0] rsp_node,
    output logic [NW-1:0] rsp_src,
    output logic [AW-1:0] rsp_addr,
    output logic [DW-1:0] rsp_data,
    input  logic          own_valid,
    input  logic [DW-1:0] own_data,
    output logic          mem_req_valid,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_data,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          dma_rsp_valid,
    output logic [DW-1:0] dma_rsp_data
);

    dir_state_e    state, nxt;
    rsp_kind_e     kind;
    logic          take_req, take_dma;
    logic          cur_dma, cur_wb, cur_write;
    logic [AW-1:0] cur_addr;
    logic [NW-1:0] cur_node;
    logic [DW-1:0] cur_data;
    logic          own_vld;
    logic [NW-1:0] own_node;
    logic          tbl_we, tbl_vld;
    logic [NW-1:0] tbl_node;

    mi_dir_arb u_arb (
        .idle      (state == ST_IDLE),
        .req_valid (req_valid),
        .dma_valid (dma_valid),
        .req_ready (req_ready),
        .dma_ready (dma_ready),
        .take_req  (take_req),
        .take_dma  (take_dma)
    );

    mi_owner_table #(.BLOCKS(BLOCKS), .NODES(NODES)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (cur_addr),
        .rd_vld  (own_vld),
        .rd_node (own_node),
        .wr_en   (tbl_we),
        .wr_addr (cur_addr),
        .wr_vld  (tbl_vld),
        .wr_node (tbl_node)
    );

    // State register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_dma   <= 1'b0;
            cur_wb    <= 1'b0;
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_node  <= '0;
            cur_data  <= '0;
        end else begin
            state <= nxt;
            if (take_req || take_dma) begin
                cur_dma   <= take_dma;
                cur_wb    <= req_wb;
                cur_write <= dma_write;
                cur_addr  <= take_req ? req_addr : dma_addr;
                cur_node  <= req_node;
                cur_data  <= take_req ? req_data : dma_data;
            end
        end
    end

    // Outputs, table updates and next state
    always_comb begin
        nxt           = state;
        rsp_valid     = 1'b0;
        kind          = RK_DATA;
        rsp_node      = '0;
        rsp_src       = '0;
        rsp_data      = '0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_data  = '0;
        dma_rsp_valid = 1'b0;
        dma_rsp_data  = '0;
        tbl_we        = 1'b0;
        tbl_vld       = 1'b0;
        tbl_node      = '0;
        unique case (state)
            ST_IDLE: begin
                if (take_req || take_dma) nxt = ST_EXEC;
            end
            ST_EXEC: begin
                nxt = ST_IDLE;
                if (cur_dma) begin
                    if (own_vld) begin
                        rsp_valid = 1'b1;
                        kind      = RK_INV;
                        rsp_node  = own_node;
                        nxt       = ST_INVW;
                    end else if (cur_write) begin
                        mem_req_valid = 1'b1;
                        mem_req_write = 1'b1;
                        mem_req_data  = cur_data;
                        dma_rsp_valid = 1'b1;
                    end else begin
                        mem_req_valid = 1'b1;
                        nxt           = ST_MEMW;
                    end
                end else if (!cur_wb) begin
                    if (own_vld) begin
                        rsp_valid = 1'b1;
                        kind      = RK_FWD;
                        rsp_node  = own_node;
                        rsp_src   = cur_node;
                        tbl_we    = 1'b1;
                        tbl_vld   = 1'b1;
                        tbl_node  = cur_node;
                    end else begin
                        mem_req_valid = 1'b1;
                        nxt           = ST_MEMW;
                    end
                end else begin
                    rsp_valid = 1'b1;
                    rsp_node  = cur_node;
                    if (own_vld && own_node == cur_node) begin
                        kind          = RK_ACK;
                        mem_req_valid = 1'b1;
                        mem_req_write = 1'b1;
                        mem_req_data  = cur_data;
                        tbl_we        = 1'b1;
                    end else begin
                        kind = RK_NACK;
                    end
                end
            end
            ST_MEMW: begin
                if (mem_rsp_valid) begin
                    nxt = ST_IDLE;
                    if (cur_dma) begin
                        dma_rsp_valid = 1'b1;
                        dma_rsp_data  = mem_rsp_data;
                    end else begin
                        rsp_valid = 1'b1;
                        kind      = RK_DATA;
                        rsp_node  = cur_node;
                        rsp_data  = mem_rsp_data;
                        tbl_we    = 1'b1;
                        tbl_vld   = 1'b1;
                        tbl_node  = cur_node;
                    end
                end
            end
            ST_INVW: begin
                if (own_valid) begin
                    nxt           = ST_IDLE;
                    mem_req_valid = 1'b1;
                    mem_req_write = 1'b1;
                    mem_req_data  = cur_write ? cur_data : own_data;
                    dma_rsp_valid = 1'b1;
                    dma_rsp_data  = cur_write ? '0 : own_data;
                    tbl_we        = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign rsp_kind     = kind;
    assign rsp_addr     = cur_addr;
    assign mem_req_addr = cur_addr;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (!req_ready && !dma_ready));

    // R5
    nack_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd3) |-> !mem_req_valid);

    // R4
    ack_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd2) |-> (mem_req_valid && mem_req_write));

    // R3
    fwd_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd1) |-> !mem_req_valid);

    // R6
    inv_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 3'd4) |=> (!req_ready && !dma_ready));

    // R9
    cache_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dma_valid) |-> !dma_ready);

endmodule

// File: tb/sim_mi_home_dir.sv
`timescale 1ns/1ps
module sim_mi_home_dir;

    localparam int BLOCKS = 16;
    localparam int NODES  = 4;
    localparam int DW     = 32;
    localparam int AW     = 4;
    localparam int NW     = 2;

    typedef struct packed {
        logic [1:0]    ch;
        logic [2:0]    kind;
        logic [NW-1:0] node;
        logic [NW-1:0] src;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          wr;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_wb = 0, dma_valid = 0, dma_write = 0;
    logic [AW-1:0] req_addr = '0, dma_addr = '0;
    logic [NW-1:0] req_node = '0;
    logic [DW-1:0] req_data = '0, dma_data = '0, own_data = '0, mem_rsp_data = '0;
    logic own_valid = 0, mem_rsp_valid = 0;
    logic req_ready, dma_ready, rsp_valid, mem_req_valid, mem_req_write, dma_rsp_valid;
    logic [2:0] rsp_kind;
    logic [NW-1:0] rsp_node, rsp_src;
    logic [AW-1:0] rsp_addr, mem_req_addr;
    logic [DW-1:0] rsp_data, mem_req_data, dma_rsp_data;

    int total = 0;
    int fails = 0;
    ev_t   exp_q [$];
    string tag_q [$];

    logic          m_vld [BLOCKS];
    logic [NW-1:0] m_own [BLOCKS];
    logic          p_dma, p_write;
    logic [NW-1:0] p_node;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_data;

    always #2.5 clk = ~clk;

    mi_home_dir #(.BLOCKS(BLOCKS), .NODES(NODES), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_wb(req_wb),
        .req_addr(req_addr), .req_node(req_node), .req_data(req_data),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_write(dma_write),
        .dma_addr(dma_addr), .dma_data(dma_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_node(rsp_node),
        .rsp_src(rsp_src), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .own_valid(own_valid), .own_data(own_data),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .dma_rsp_valid(dma_rsp_valid), .dma_rsp_data(dma_rsp_data)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(logic [1:0] ch, logic [2:0] k, logic [NW-1:0] n, logic [NW-1:0] s,
                        logic [AW-1:0] a, logic [DW-1:0] d, logic w, string tag);
        ev_t e;
        e.ch = ch; e.kind = k; e.node = n; e.src = s; e.addr = a; e.data = d; e.wr = w;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic observe(ev_t got);
        ev_t   e;
        string t;
        total++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL unexpected event: actual %0h expected none", got);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (got !== e) begin
                fails++;
                $display("FAIL %s: actual %0h expected %0h", t, got, e);
            end
        end
    endtask

    // Monitor: late in the low phase, one sample per cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (rsp_valid)
                    observe({2'd0, rsp_kind, rsp_node, rsp_src, rsp_addr, rsp_data, 1'b0});
                if (mem_req_valid)
                    observe({2'd1, 3'd0, 2'd0, 2'd0, mem_req_addr, mem_req_data, mem_req_write});
                if (dma_rsp_valid)
                    observe({2'd2, 3'd0, 2'd0, 2'd0, 4'd0, dma_rsp_data, 1'b0});
            end
        end
    end

    // Expectation builders from the bench owner model
    task automatic expect_req(logic wb, logic [AW-1:0] a, logic [NW-1:0] n, logic [DW-1:0] d, string tag);
        if (!wb) begin
            if (m_vld[a]) begin
                push(0, 3'd1, m_own[a], n, a, '0, 0, tag);
                m_own[a] = n;
            end else begin
                push(1, 0, 0, 0, a, '0, 0, tag);
                p_dma = 0; p_node = n; p_addr = a;
            end
        end else if (m_vld[a] && m_own[a] == n) begin
            push(0, 3'd2, n, 0, a, '0, 0, tag);
            push(1, 0, 0, 0, a, d, 1, tag);
            m_vld[a] = 0;
        end else begin
            push(0, 3'd3, n, 0, a, '0, 0, tag);
        end
    endtask

    task automatic expect_dma(logic w, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        p_dma = 1; p_write = w; p_addr = a; p_data = d;
        if (m_vld[a]) begin
            push(0, 3'd4, m_own[a], 0, a, '0, 0, tag);
        end else if (w) begin
            push(1, 0, 0, 0, a, d, 1, tag);
            push(2, 0, 0, 0, 0, '0, 0, tag);
        end else begin
            push(1, 0, 0, 0, a, '0, 0, tag);
        end
    endtask

    task automatic send_req(logic wb, logic [AW-1:0] a, logic [NW-1:0] n, logic [DW-1:0] d, string tag);
        @(negedge clk);
        expect_req(wb, a, n, d, tag);
        req_valid = 1; req_wb = wb; req_addr = a; req_node = n; req_data = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic send_dma(logic w, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        @(negedge clk);
        expect_dma(w, a, d, tag);
        dma_valid = 1; dma_write = w; dma_addr = a; dma_data = d;
        @(negedge clk);
        dma_valid = 0;
    endtask

    task automatic mem_reply(logic [DW-1:0] d, string tag);
        @(negedge clk);
        if (p_dma) push(2, 0, 0, 0, 0, d, 0, tag);
        else begin
            push(0, 3'd0, p_node, 0, p_addr, d, 0, tag);
            m_vld[p_addr] = 1; m_own[p_addr] = p_node;
        end
        mem_rsp_valid = 1; mem_rsp_data = d;
        @(negedge clk);
        mem_rsp_valid = 0;
    endtask

    task automatic own_reply(logic [DW-1:0] d, string tag);
        @(negedge clk);
        push(1, 0, 0, 0, p_addr, p_write ? p_data : d, 1, tag);
        push(2, 0, 0, 0, 0, p_write ? '0 : d, 0, tag);
        m_vld[p_addr] = 0;
        own_valid = 1; own_data = d;
        @(negedge clk);
        own_valid = 0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < BLOCKS; i++) begin m_vld[i] = 0; m_own[i] = '0; end
        p_dma = 0; p_write = 0; p_node = '0; p_addr = '0; p_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check("R1 req_ready", req_ready, 1);
        check("R1 dma_ready", dma_ready, 1);
        check("R1 quiet", {rsp_valid, mem_req_valid, dma_rsp_valid}, 0);
        // R1 no owner after reset: writeback is refused
        send_req(1, 4'd5, 2'd0, 32'h11, "R1 wb after reset");

        // R2 fetch, with R8 stall and R10 no timeout
        send_req(0, 4'd3, 2'd1, '0, "R2 getx fetch");
        @(negedge clk);
        req_valid = 1; req_wb = 0; req_addr = 4'd7; req_node = 2'd2; dma_valid = 1;
        #1;
        check("R8 req_ready stalled", req_ready, 0);
        check("R8 dma_ready stalled", dma_ready, 0);
        repeat (40) @(negedge clk);
        #1;
        check("R10 still waiting", req_ready, 0);
        req_valid = 0; dma_valid = 0;
        mem_reply(32'hA5A5_0003, "R2 data fill");

        send_req(0, 4'd3, 2'd2, '0, "R3 forward");
        send_req(1, 4'd3, 2'd1, 32'hDEAD, "R5 stale wb");
        send_req(1, 4'd3, 2'd2, 32'h1234, "R4 owner wb");
        send_req(0, 4'd3, 2'd0, '0, "R4 owner cleared");
        mem_reply(32'h0303, "R2 refill");

        send_dma(0, 4'd3, '0, "R6 dma read inv");
        own_reply(32'hBEEF, "R6 dma read recall");
        send_req(0, 4'd3, 2'd3, '0, "R6 owner cleared");
        mem_reply(32'h3333, "R2 fill node3");
        send_dma(1, 4'd3, 32'h77, "R6 dma write inv");
        own_reply(32'h55, "R6 dma write recall");

        send_dma(0, 4'd9, '0, "R7 dma read mem");
        mem_reply(32'h99, "R7 dma read data");

        // R9 both channels valid
        @(negedge clk);
        expect_req(1, 4'd12, 2'd1, 32'h1, "R9 cache first");
        expect_dma(1, 4'd12, 32'hC0, "R9 dma later");
        req_valid = 1; req_wb = 1; req_addr = 4'd12; req_node = 2'd1; req_data = 32'h1;
        dma_valid = 1; dma_write = 1; dma_addr = 4'd12; dma_data = 32'hC0;
        #1;
        check("R9 dma_ready low", dma_ready, 0);
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        @(negedge clk);
        dma_valid = 0;

        // R11 edge addresses
        send_req(0, 4'd15, 2'd3, '0, "R11 fetch top");
        mem_reply(32'hF0F0, "R11 fill top");
        send_req(0, 4'd0, 2'd1, '0, "R11 fetch bottom");
        mem_reply(32'h0F0F, "R11 fill bottom");
        send_req(0, 4'd15, 2'd3, '0, "R3 self forward");
        send_req(1, 4'd0, 2'd1, 32'hAB, "R11 wb bottom");
        send_req(1, 4'd15, 2'd3, 32'hCD, "R11 wb top");

        repeat (4) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL missing events: actual %0d left expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule